// File: doc/BRIEF.md
# Block and Byte Transfer Sequencer

This block sits between a 16-bit word FIFO and a byte-wide card data port and runs multi-block data transfers. In the card-to-FIFO direction it gathers card bytes in pairs into FIFO words, lower byte first. In the FIFO-to-card direction it splits each head word into bytes, lower byte first. It keeps a remaining-bytes counter for the current block and a remaining-blocks counter for the whole transfer.

A command that carries data starts a transfer. That command clears the FIFO and latches the direction. The block pauses when the FIFO limits require it, reloads its counters at every block boundary, and pulses a completion flag after the last byte. Software programs the block length and the block count as "value minus one" fields. Reading them back returns the remaining counts, not the programmed values.

Top module: `blk_xfer_seq`

## Requirements
- R1: A write of the length field stores field+1 as the block length (1 to 2048) and loads the same value into the remaining-bytes counter. `len_rd_o` always shows the remaining-bytes counter.
- R2: A write of the count field stores field+1 as the block count, loads the remaining-blocks counter with it, and reloads the remaining-bytes counter from the stored block length. `cnt_rd_o` always shows the remaining-blocks counter.
- R3: A command with `cmd_is_data_i`=1 pulses `fifo_clear_o` in the same cycle, sets `active_o`, and latches `cmd_dir_i` into `dir_o` (1 = card to FIFO, 0 = FIFO to card). A command with `cmd_is_data_i`=0 clears `active_o` and stops all byte movement.
- R4: Card to FIFO: the first byte of a word lands in bits 7:0 and the second byte in bits 15:8. The word is pushed after its second byte. If the block ends after the first byte, the word is pushed at once with bits 15:8 zero.
- R5: FIFO to card: bits 7:0 of the head word go out first, then bits 15:8 if the block still has bytes left. The word is popped with its last byte.
- R6: Card to FIFO: a new word is begun only while `fifo_level_i` <= `af_level_i`. A word already begun is always completed.
- R7: FIFO to card: `crd_tx_valid_o` stays low while `fifo_level_i` is zero.
- R8: Each byte moved lowers the remaining-bytes counter. When that counter reaches zero, it reloads from the block length and the remaining-blocks counter decrements.
- R9: When the last byte of the last block moves, the remaining-blocks counter reloads from the block count, `active_o` drops, and `done_o` is high for exactly the next cycle.
- R10: When the card handshake and the FIFO allow it, one byte moves every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_we_i | input | 1 | Write strobe for the block length field |
| len_wdata_i | input | 11 | Block length minus one |
| cnt_we_i | input | 1 | Write strobe for the block count field |
| cnt_wdata_i | input | 11 | Block count minus one |
| len_rd_o | output | 12 | Remaining bytes in the current block |
| cnt_rd_o | output | 12 | Remaining blocks in the transfer |
| cmd_start_i | input | 1 | Command issued this cycle |
| cmd_is_data_i | input | 1 | Issued command carries data |
| cmd_dir_i | input | 1 | Direction of the data command, 1 = card to FIFO |
| af_level_i | input | 5 | Almost-full level of the FIFO |
| fifo_level_i | input | 6 | Words currently held in the FIFO |
| fifo_clear_o | output | 1 | Reset the FIFO indices |
| fifo_push_o | output | 1 | Push `fifo_push_data_o` |
| fifo_push_data_o | output | 16 | Packed word to push |
| fifo_pop_o | output | 1 | Pop the head word |
| fifo_head_i | input | 16 | FIFO head word |
| crd_rx_valid_i | input | 1 | Card offers a byte |
| crd_rx_data_i | input | 8 | Byte from the card |
| crd_rx_ready_o | output | 1 | Block takes the offered byte |
| crd_tx_valid_o | output | 1 | Block offers a byte to the card |
| crd_tx_data_o | output | 8 | Byte to the card |
| crd_tx_ready_i | input | 1 | Card takes the offered byte |
| active_o | output | 1 | Transfer in progress |
| dir_o | output | 1 | Latched direction |
| done_o | output | 1 | One-cycle transfer completion pulse |

## Verification
Several events can coincide with the last byte of a block: the word push or pop, the byte counter reload, the block counter decrement and, on the final block, the end of the transfer. With odd lengths, a half-filled word is pushed in the same cycle as the block boundary. The bench provokes these cases by sweeping block lengths 1 to 5 against block counts 1 to 3 in both directions, with and without gaps in the handshake. It judges them by comparing every pushed word and every sent byte with an arithmetic model, and by checking both remaining counters after every byte.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic {
    DIR_TO_CARD   = 1'b0,
    DIR_FROM_CARD = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int FIELD_W = 11,
  parameter int CNT_W   = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               len_we_i,
  input  logic [FIELD_W-1:0] len_wdata_i,
  input  logic               cnt_we_i,
  input  logic [FIELD_W-1:0] cnt_wdata_i,
  input  logic               step_i,
  output logic [CNT_W-1:0]   byte_left_o,
  output logic [CNT_W-1:0]   blk_left_o,
  output logic               last_byte_o,
  output logic               xfer_end_o
);
  logic [CNT_W-1:0] blen_q, nblk_q, bcnt_q, kcnt_q;
  logic [CNT_W-1:0] len_dec, cnt_dec;

  assign len_dec     = CNT_W'(len_wdata_i) + CNT_W'(1);
  assign cnt_dec     = CNT_W'(cnt_wdata_i) + CNT_W'(1);
  assign last_byte_o = (bcnt_q == CNT_W'(1));
  assign xfer_end_o  = last_byte_o && (kcnt_q == CNT_W'(1));
  assign byte_left_o = bcnt_q;
  assign blk_left_o  = kcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blen_q <= '0;
      nblk_q <= '0;
      bcnt_q <= '0;
      kcnt_q <= '0;
    end else begin
      if (len_we_i) blen_q <= len_dec;
      if (cnt_we_i) nblk_q <= cnt_dec;
      // register writes take priority over counting
      if (len_we_i) begin
        bcnt_q <= len_dec;
      end else if (cnt_we_i) begin
        bcnt_q <= blen_q;
      end else if (step_i) begin
        bcnt_q <= last_byte_o ? blen_q : bcnt_q - CNT_W'(1);
      end
      if (cnt_we_i) begin
        kcnt_q <= cnt_dec;
      end else if (step_i && last_byte_o && !len_we_i) begin
        kcnt_q <= xfer_end_o ? nblk_q : kcnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rx_fire_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              tx_fire_i,
  input  logic              last_byte_i,
  input  logic [WORD_W-1:0] head_i,
  output logic              half_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              pop_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  logic              half_q;
  logic [BYTE_W-1:0] lo_q;
  logic              word_end;

  // a word closes on its upper byte or on the last byte of a block
  assign word_end    = half_q || last_byte_i;
  assign half_o      = half_q;
  assign push_o      = rx_fire_i && word_end;
  assign push_data_o = half_q ? {rx_byte_i, lo_q} : {BYTE_W'(0), rx_byte_i};
  assign pop_o       = tx_fire_i && word_end;
  assign tx_byte_o   = half_q ? head_i[WORD_W-1:BYTE_W] : head_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      lo_q   <= '0;
    end else if (clear_i) begin
      half_q <= 1'b0;
    end else if (rx_fire_i || tx_fire_i) begin
      half_q <= !word_end;
      if (rx_fire_i && !half_q) lo_q <= rx_byte_i;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int LEN_FIELD_W = 11,
  parameter int LVL_W       = 6,
  parameter int AF_W        = 5,
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = LEN_FIELD_W + 1,
  parameter int WORD_W      = 2 * BYTE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   len_we_i,
  input  logic [LEN_FIELD_W-1:0] len_wdata_i,
  input  logic                   cnt_we_i,
  input  logic [LEN_FIELD_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0]       len_rd_o,
  output logic [CNT_W-1:0]       cnt_rd_o,
  input  logic                   cmd_start_i,
  input  logic                   cmd_is_data_i,
  input  logic                   cmd_dir_i,
  input  logic [AF_W-1:0]        af_level_i,
  input  logic [LVL_W-1:0]       fifo_level_i,
  output logic                   fifo_clear_o,
  output logic                   fifo_push_o,
  output logic [WORD_W-1:0]      fifo_push_data_o,
  output logic                   fifo_pop_o,
  input  logic [WORD_W-1:0]      fifo_head_i,
  input  logic                   crd_rx_valid_i,
  input  logic [BYTE_W-1:0]      crd_rx_data_i,
  output logic                   crd_rx_ready_o,
  output logic                   crd_tx_valid_o,
  output logic [BYTE_W-1:0]      crd_tx_data_o,
  input  logic                   crd_tx_ready_i,
  output logic                   active_o,
  output logic                   dir_o,
  output logic                   done_o
);
  logic      active_q, done_q;
  xfer_dir_e dir_q;
  logic      half_w, last_byte_w, xfer_end_w;
  logic      rx_fire, tx_fire, step, below_af;

  assign below_af       = fifo_level_i <= LVL_W'(af_level_i);
  assign crd_rx_ready_o = active_q && (dir_q == DIR_FROM_CARD) && (half_w || below_af);
  assign crd_tx_valid_o = active_q && (dir_q == DIR_TO_CARD) && (fifo_level_i != '0);
  assign rx_fire        = crd_rx_valid_i && crd_rx_ready_o;
  assign tx_fire        = crd_tx_valid_o && crd_tx_ready_i;
  assign step           = rx_fire || tx_fire;
  assign fifo_clear_o   = cmd_start_i && cmd_is_data_i;
  assign active_o       = active_q;
  assign dir_o          = dir_q;
  assign done_o         = done_q;

  xfer_count #(.FIELD_W(LEN_FIELD_W), .CNT_W(CNT_W)) i_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .len_we_i    (len_we_i),
    .len_wdata_i (len_wdata_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .step_i      (step),
    .byte_left_o (len_rd_o),
    .blk_left_o  (cnt_rd_o),
    .last_byte_o (last_byte_w),
    .xfer_end_o  (xfer_end_w)
  );

  byte_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (fifo_clear_o),
    .rx_fire_i   (rx_fire),
    .rx_byte_i   (crd_rx_data_i),
    .tx_fire_i   (tx_fire),
    .last_byte_i (last_byte_w),
    .head_i      (fifo_head_i),
    .half_o      (half_w),
    .push_o      (fifo_push_o),
    .push_data_o (fifo_push_data_o),
    .pop_o       (fifo_pop_o),
    .tx_byte_o   (crd_tx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dir_q    <= DIR_TO_CARD;
      done_q   <= 1'b0;
    end else begin
      done_q <= step && xfer_end_w;
      if (cmd_start_i) begin
        active_q <= cmd_is_data_i;
        if (cmd_is_data_i) dir_q <= xfer_dir_e'(cmd_dir_i);
      end else if (step && xfer_end_w) begin
        active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int LEN_FIELD_W = 11,
  parameter int LVL_W       = 6,
  parameter int AF_W        = 5,
  parameter int CNT_W       = LEN_FIELD_W + 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   len_we_i,
  input logic [LEN_FIELD_W-1:0] len_wdata_i,
  input logic                   cnt_we_i,
  input logic [LEN_FIELD_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0]       len_rd_o,
  input logic [CNT_W-1:0]       cnt_rd_o,
  input logic                   cmd_start_i,
  input logic                   cmd_is_data_i,
  input logic [AF_W-1:0]        af_level_i,
  input logic [LVL_W-1:0]       fifo_level_i,
  input logic                   fifo_push_o,
  input logic                   fifo_pop_o,
  input logic                   crd_rx_valid_i,
  input logic                   crd_rx_ready_o,
  input logic                   crd_tx_valid_o,
  input logic                   crd_tx_ready_i,
  input logic                   active_o,
  input logic                   dir_o,
  input logic                   done_o,
  input logic                   half_w
);
  assert_len_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |=> len_rd_o == CNT_W'($past(len_wdata_i)) + CNT_W'(1));

  assert_cnt_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && !len_we_i |=> cnt_rd_o == CNT_W'($past(cnt_wdata_i)) + CNT_W'(1));

  assert_push_rx_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> active_o && dir_o);

  assert_pop_tx_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> active_o && !dir_o);

  assert_af_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_rx_ready_o && !half_w |-> fifo_level_i <= LVL_W'(af_level_i));

  assert_tx_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crd_tx_valid_o |-> fifo_level_i != '0);

  assert_done_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o || $past(cmd_start_i && cmd_is_data_i));

  assert_one_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({crd_rx_valid_i && crd_rx_ready_o, crd_tx_valid_o && crd_tx_ready_i}));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .LEN_FIELD_W(LEN_FIELD_W), .LVL_W(LVL_W), .AF_W(AF_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .len_we_i       (len_we_i),
  .len_wdata_i    (len_wdata_i),
  .cnt_we_i       (cnt_we_i),
  .cnt_wdata_i    (cnt_wdata_i),
  .len_rd_o       (len_rd_o),
  .cnt_rd_o       (cnt_rd_o),
  .cmd_start_i    (cmd_start_i),
  .cmd_is_data_i  (cmd_is_data_i),
  .af_level_i     (af_level_i),
  .fifo_level_i   (fifo_level_i),
  .fifo_push_o    (fifo_push_o),
  .fifo_pop_o     (fifo_pop_o),
  .crd_rx_valid_i (crd_rx_valid_i),
  .crd_rx_ready_o (crd_rx_ready_o),
  .crd_tx_valid_o (crd_tx_valid_o),
  .crd_tx_ready_i (crd_tx_ready_i),
  .active_o       (active_o),
  .dir_o          (dir_o),
  .done_o         (done_o),
  .half_w         (half_w)
);

// File: tb/test_blk_xfer_seq.sv
`timescale 1ns/1ps
module test_blk_xfer_seq;
  localparam int LEN_FIELD_W = 11;
  localparam int LVL_W       = 6;
  localparam int AF_W        = 5;
  localparam int BYTE_W      = 8;
  localparam int CNT_W       = LEN_FIELD_W + 1;
  localparam int WORD_W      = 2 * BYTE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                   len_we_i = 1'b0, cnt_we_i = 1'b0;
  logic [LEN_FIELD_W-1:0] len_wdata_i = '0, cnt_wdata_i = '0;
  logic [CNT_W-1:0]       len_rd_o, cnt_rd_o;
  logic                   cmd_start_i = 1'b0, cmd_is_data_i = 1'b0, cmd_dir_i = 1'b0;
  logic [AF_W-1:0]        af_level_i = '1;
  logic [LVL_W-1:0]       fifo_level_i;
  logic                   fifo_clear_o, fifo_push_o, fifo_pop_o;
  logic [WORD_W-1:0]      fifo_push_data_o, fifo_head_i;
  logic                   crd_rx_valid_i = 1'b0, crd_rx_ready_o;
  logic [BYTE_W-1:0]      crd_rx_data_i, crd_tx_data_o;
  logic                   crd_tx_valid_o, crd_tx_ready_i = 1'b0;
  logic                   active_o, dir_o, done_o;

  blk_xfer_seq i_blk_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .len_we_i(len_we_i), .len_wdata_i(len_wdata_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .len_rd_o(len_rd_o), .cnt_rd_o(cnt_rd_o),
    .cmd_start_i(cmd_start_i), .cmd_is_data_i(cmd_is_data_i), .cmd_dir_i(cmd_dir_i),
    .af_level_i(af_level_i), .fifo_level_i(fifo_level_i),
    .fifo_clear_o(fifo_clear_o), .fifo_push_o(fifo_push_o),
    .fifo_push_data_o(fifo_push_data_o), .fifo_pop_o(fifo_pop_o),
    .fifo_head_i(fifo_head_i),
    .crd_rx_valid_i(crd_rx_valid_i), .crd_rx_data_i(crd_rx_data_i),
    .crd_rx_ready_o(crd_rx_ready_o),
    .crd_tx_valid_o(crd_tx_valid_o), .crd_tx_data_o(crd_tx_data_o),
    .crd_tx_ready_i(crd_tx_ready_i),
    .active_o(active_o), .dir_o(dir_o), .done_o(done_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FIL%s %s: actual 0x%0h expected 0x%0h", "", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rxb(int k);
    return 8'((k * 7 + 3) & 255);
  endfunction
  function automatic logic [15:0] txw(int m);
    return 16'((m * 773 + 4386) & 65535);
  endfunction

  // bench-side FIFO and card models
  int cyc = 0, lvl = 0, txrd = 0, txwr = 0, rx_idx = 0;
  logic [15:0] txmem [0:63];
  bit rx_en = 0, tx_en = 0, drain_en = 0, load_en = 0, drain_now = 0, load_now = 0;
  int pat = 0, ddiv = 1;
  int cur_blen = 1, cur_nblk = 1, cur_af = 31, tot_words = 0;
  int bytes_done = 0, exp_k = 0, exp_p = 0, tx_m = 0, tx_p = 0;
  int words_seen = 0, done_cnt = 0, act_cyc = 0;
  bit rx_hs_s = 0, tx_hs_s = 0, push_s = 0, pop_s = 0;
  logic [15:0] pdata_s = '0;
  logic [7:0]  txb_s = '0;

  assign fifo_level_i  = LVL_W'(lvl);
  assign fifo_head_i   = txmem[txrd & 63];
  assign crd_rx_data_i = rxb(rx_idx);

  initial for (int i = 0; i < 64; i++) txmem[i] = '0;

  always @(posedge clk) begin
    rx_hs_s <= crd_rx_valid_i && crd_rx_ready_o;
    tx_hs_s <= crd_tx_valid_o && crd_tx_ready_i;
    push_s  <= fifo_push_o;
    pdata_s <= fifo_push_data_o;
    pop_s   <= fifo_pop_o;
    txb_s   <= crd_tx_data_o;
    if (crd_rx_valid_i && crd_rx_ready_o) rx_idx <= rx_idx + 1;
    if (fifo_clear_o) begin
      lvl <= 0; txrd <= 0; txwr <= 0;
    end else begin
      lvl <= lvl + int'(fifo_push_o) - int'(drain_now) - int'(fifo_pop_o) + int'(load_now);
      if (fifo_pop_o) txrd <= txrd + 1;
      if (load_now) begin
        txmem[txwr & 63] <= txw(txwr);
        txwr <= txwr + 1;
      end
    end
  end

  always @(negedge clk) begin
    bit ok_pat;
    cyc++;
    if (push_s) begin
      logic [15:0] ew;
      ew[7:0] = rxb(exp_k);
      if (exp_p + 1 < cur_blen) begin
        ew[15:8] = rxb(exp_k + 1); exp_k += 2; exp_p += 2;
      end else begin
        ew[15:8] = 8'h00; exp_k += 1; exp_p += 1;
      end
      if (exp_p >= cur_blen) exp_p = 0;
      chk(pdata_s == ew, "R4 packed word", int'(pdata_s), int'(ew));
      words_seen++;
    end
    if (tx_hs_s) begin
      logic [7:0] eb;
      bit wend;
      eb = (tx_p % 2 == 0) ? txw(tx_m)[7:0] : txw(tx_m)[15:8];
      wend = (tx_p % 2 == 1) || (tx_p == cur_blen - 1);
      chk(txb_s == eb, "R5 sent byte", int'(txb_s), int'(eb));
      chk(pop_s == wend, "R5 pop timing", int'(pop_s), int'(wend));
      if (wend) tx_m++;
      tx_p++;
      if (tx_p == cur_blen) tx_p = 0;
    end
    if (rx_hs_s || tx_hs_s) begin
      bytes_done++;
      if (bytes_done < cur_blen * cur_nblk) begin
        chk(len_rd_o == CNT_W'(cur_blen - bytes_done % cur_blen), "R8 bytes left",
            int'(len_rd_o), cur_blen - bytes_done % cur_blen);
        chk(cnt_rd_o == CNT_W'(cur_nblk - bytes_done / cur_blen), "R8 blocks left",
            int'(cnt_rd_o), cur_nblk - bytes_done / cur_blen);
      end else begin
        chk(!active_o && done_o, "R9 end of transfer", {active_o, done_o}, 1);
        chk(cnt_rd_o == CNT_W'(cur_nblk), "R9 block reload", int'(cnt_rd_o), cur_nblk);
        chk(len_rd_o == CNT_W'(cur_blen), "R8 byte reload", int'(len_rd_o), cur_blen);
      end
    end
    if (done_o) done_cnt++;
    if (active_o) act_cyc++;
    if (active_o && !dir_o && lvl == 0)
      chk(crd_tx_valid_o == 1'b0, "R7 empty stall", int'(crd_tx_valid_o), 0);
    if (active_o && dir_o && lvl > cur_af && ((bytes_done % cur_blen) % 2 == 0))
      chk(crd_rx_ready_o == 1'b0, "R6 almost-full stall", int'(crd_rx_ready_o), 0);
    ok_pat = (pat == 0) || (cyc % 5 != 4);
    crd_rx_valid_i = rx_en && ok_pat;
    crd_tx_ready_i = tx_en && ok_pat;
    drain_now = drain_en && (lvl > 0) && (cyc % ddiv == 0);
    load_now  = load_en && (lvl < 32) && (txwr < tot_words) && (cyc % ddiv == 0);
  end

  task automatic prog(int bl, int nb);
    @(negedge clk); #2 len_we_i = 1'b1; len_wdata_i = LEN_FIELD_W'(bl - 1);
    @(negedge clk); #2 len_we_i = 1'b0; cnt_we_i = 1'b1; cnt_wdata_i = LEN_FIELD_W'(nb - 1);
    @(negedge clk); #2 cnt_we_i = 1'b0;
  endtask

  task automatic start(bit rx, int bl, int nb, int af, int p, int dv, bit hold);
    prog(bl, nb);
    cur_blen = bl; cur_nblk = nb; cur_af = rx ? af : 31;
    af_level_i = AF_W'(cur_af);
    tot_words = nb * ((bl + 1) / 2);
    bytes_done = 0; exp_k = rx_idx; exp_p = 0; tx_m = 0; tx_p = 0;
    words_seen = 0; done_cnt = 0; act_cyc = 0; pat = p; ddiv = dv;
    rx_en = rx; tx_en = !rx; drain_en = rx && !hold; load_en = !rx;
    cmd_start_i = 1'b1; cmd_is_data_i = 1'b1; cmd_dir_i = rx;
    #1 chk(fifo_clear_o == 1'b1, "R3 fifo clear", int'(fifo_clear_o), 1);
    @(negedge clk); #2 cmd_start_i = 1'b0;
    chk(active_o && (dir_o == rx), "R3 start", {active_o, dir_o}, {1'b1, rx});
  endtask

  task automatic finish_xfer(bit rx);
    int i = 0;
    while (done_cnt == 0 && i < 4000) begin
      @(negedge clk); #2; i++;
    end
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(active_o == 1'b0, "R9 inactive", int'(active_o), 0);
    if (rx) chk(words_seen == tot_words, "R4 word count", words_seen, tot_words);
    else    chk(tx_m == tot_words, "R5 word count", tx_m, tot_words);
    @(negedge clk); #2;
    chk(done_o == 1'b0, "R9 single cycle pulse", int'(done_o), 0);
    chk(len_rd_o == CNT_W'(cur_blen) && cnt_rd_o == CNT_W'(cur_nblk), "R9 readback",
        int'({len_rd_o, cnt_rd_o}), int'({CNT_W'(cur_blen), CNT_W'(cur_nblk)}));
    rx_en = 0; tx_en = 0; drain_en = 0; load_en = 0;
    @(negedge clk); #2;
    while (lvl != 0) begin
      drain_en = 1;
      @(negedge clk); #2;
    end
    drain_en = 0;
  endtask

  initial begin
    #2000;
    @(negedge clk); #2 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(len_rd_o == '0 && cnt_rd_o == '0, "R1 reset counters", int'({len_rd_o, cnt_rd_o}), 0);
    chk(!active_o && !crd_rx_ready_o && !crd_tx_valid_o && !done_o, "R3 reset idle",
        int'({active_o, crd_rx_ready_o, crd_tx_valid_o, done_o}), 0);

    // R1 and R2: field plus one at both extremes
    prog(2048, 2048);
    chk(len_rd_o == 12'd2048, "R1 max length", int'(len_rd_o), 2048);
    chk(cnt_rd_o == 12'd2048, "R2 max count", int'(cnt_rd_o), 2048);
    prog(1, 1);
    chk(len_rd_o == 12'd1 && cnt_rd_o == 12'd1, "R1 min length", int'({len_rd_o, cnt_rd_o}),
        int'({12'd1, 12'd1}));

    // sweep both directions, lengths 1..5, counts 1..3
    for (int d = 0; d < 2; d++)
      for (int bl = 1; bl <= 5; bl++)
        for (int nb = 1; nb <= 3; nb++) begin
          start(d == 0, bl, nb, (bl + nb) % 4, (bl + nb) % 2, 1 + bl % 3, 1'b0);
          finish_xfer(d == 0);
        end

    // R10: full speed, one byte per clock
    start(1'b1, 4, 3, 31, 0, 1, 1'b0);
    finish_xfer(1'b1);
    chk(act_cyc == 12, "R10 full rate", act_cyc, 12);

    // R6: no draining, fill stops just past the almost-full level
    start(1'b1, 16, 1, 2, 0, 1, 1'b1);
    repeat (60) @(negedge clk);
    #2;
    chk(lvl == 3, "R6 fill level", lvl, 3);
    chk(crd_rx_ready_o == 1'b0, "R6 ready held low", int'(crd_rx_ready_o), 0);
    drain_en = 1;
    finish_xfer(1'b1);

    // R3 abort by a non-data command, then R2 byte counter reload
    start(1'b1, 10, 2, 31, 0, 1, 1'b0);
    while (bytes_done < 5) begin @(negedge clk); #2; end
    cmd_start_i = 1'b1; cmd_is_data_i = 1'b0;
    @(negedge clk); #2 cmd_start_i = 1'b0;
    chk(active_o == 1'b0, "R3 abort", int'(active_o), 1'b0);
    chk(crd_rx_ready_o == 1'b0, "R3 no movement", int'(crd_rx_ready_o), 0);
    chk(len_rd_o == CNT_W'(10 - bytes_done), "R3 counter held", int'(len_rd_o), 10 - bytes_done);
    rx_en = 0;
    @(negedge clk); #2 cnt_we_i = 1'b1; cnt_wdata_i = 11'd4;
    @(negedge clk); #2 cnt_we_i = 1'b0;
    chk(len_rd_o == 12'd10, "R2 bytes reload", int'(len_rd_o), 10);
    chk(cnt_rd_o == 12'd5, "R2 count load", int'(cnt_rd_o), 5);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule